// File: doc/BRIEF.md
# Timed Wash Cycle Controller

This block sequences an automatic vehicle wash through four phases: it waits for a vehicle, runs the water for a fixed time, runs the dryer for a shorter fixed time, and then waits until the vehicle has driven out. Both phase lengths are parameters counted in ticks of a once-per-second enable, so a simulation can use short values while a real installation uses minutes. One down-counter serves both timed phases.

The vehicle sensor is asynchronous to the controller clock. It passes through a two-flop synchronizer before the sequencer sees it. The water valve and dryer outputs come straight from flops, and these flops are written on the same edge as the state. The current phase is shown on a four-bit code output. A parameter chooses a compact binary code or a one-hot code.

Top module: `wash_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the block in the idle phase with `waterOn` and `dryerOn` both low. This holds whatever phase the block was in before.
- R2: From idle, a high `carPresent` moves the block to the washing phase with `waterOn` high on the third rising edge after the input rises. The first two edges are the synchronizer.
- R3: On entry to washing, the shared timer is loaded with `WASH_TICKS`. With `tickEn` held high, washing lasts exactly `WASH_TICKS`+1 clock cycles before drying begins.
- R4: On entry to drying, the timer is loaded with `DRY_TICKS`. `waterOn` goes low and `dryerOn` goes high on the same edge. With `tickEn` held high, drying lasts exactly `DRY_TICKS`+1 cycles.
- R5: When the drying timer reaches zero, the block enters the waiting-for-exit phase with both `waterOn` and `dryerOn` low.
- R6: In waiting-for-exit, the block stays there while `carPresent` is high. It returns to idle on the third rising edge after `carPresent` falls.
- R7: The timer counts down only in cycles where `tickEn` is high. With `tickEn` low, a timed phase never ends.
- R8: `carPresent` has no effect during washing or drying. A vehicle that leaves mid-cycle does not shorten either phase.
- R9: With `ONE_HOT`=0, `stateCode` is 0 for idle, 1 for washing, 2 for drying and 3 for waiting-for-exit, with bits 3:2 zero. With `ONE_HOT`=1, the same phases read 4'b0001, 4'b0010, 4'b0100 and 4'b1000.
- R10: `waterOn` and `dryerOn` are never high together. `waterOn` is high exactly in washing, and `dryerOn` is high exactly in drying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| carPresent | input | 1 | Asynchronous vehicle sensor, high when a vehicle is in the bay |
| tickEn | input | 1 | One-cycle pulse per second that advances the phase timer |
| waterOn | output | 1 | Water valve drive, registered |
| dryerOn | output | 1 | Dryer drive, registered |
| stateCode | output | 4 | Current phase, binary or one-hot per `ONE_HOT` |

## Verification
The assertions assume that `rst` is held for at least one edge before the sensor or the tick is used. They also assume that `carPresent` changes no more than once per clock, so that the synchronized copy is a plain delayed version of it. The bench drives every input at the falling edge and holds reset low only after the outputs have settled. It uses phase lengths of four and two ticks so that the whole sequence, a long tick stall and a mid-cycle vehicle departure fit in a short run. Two instances, one for each state code, get the same stimulus, and the bench compares both codes in every check.

// File: rtl/wash_pkg.sv
package wash_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WASH = 2'b01,
    ST_DRY  = 2'b10,
    ST_EXIT = 2'b11
  } washState_t;

  // Strobes from the control to the phase timer.
  typedef struct packed {
    logic loadWash;
    logic loadDry;
  } timerCmd_t;

endpackage

// File: rtl/wash_sync.sv
module wash_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/wash_timer.sv
module wash_timer
  import wash_pkg::*;
#(
  parameter int WASH_TICKS = 300,
  parameter int DRY_TICKS  = 60,
  localparam int MAX_TICKS = (WASH_TICKS > DRY_TICKS) ? WASH_TICKS : DRY_TICKS,
  localparam int CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickEn,
  input  timerCmd_t cmd,
  output logic      timerZero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                            count <= '0;
    else if (cmd.loadWash)              count <= CNT_W'(WASH_TICKS);
    else if (cmd.loadDry)               count <= CNT_W'(DRY_TICKS);
    else if (tickEn && count != '0)     count <= count - 1'b1;
  end

  assign timerZero = (count == '0);

  // R7: without a tick or a load the count holds
  p_timer_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (!tickEn && !cmd.loadWash && !cmd.loadDry) |=> $stable(count));

  // R3: a wash load leaves the full wash duration in the counter
  p_wash_load_r3: assert property (@(posedge clk) disable iff (rst)
    cmd.loadWash |=> (count == CNT_W'(WASH_TICKS)));

  // R4: a dry load leaves the full dry duration in the counter
  p_dry_load_r4: assert property (@(posedge clk) disable iff (rst)
    cmd.loadDry |=> (count == CNT_W'(DRY_TICKS)));
endmodule

// File: rtl/wash_ctrl.sv
module wash_ctrl
  import wash_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       carSync,
  input  logic       timerZero,
  output timerCmd_t  cmd,
  output logic       waterOn,
  output logic       dryerOn,
  output logic [3:0] stateCode
);
  washState_t stateQ, stateNext;
  logic [3:0] codeNext;

  always_comb begin
    stateNext = stateQ;
    cmd       = '0;
    case (stateQ)
      ST_IDLE: if (carSync) begin
        stateNext    = ST_WASH;
        cmd.loadWash = 1'b1;
      end
      ST_WASH: if (timerZero) begin
        stateNext   = ST_DRY;
        cmd.loadDry = 1'b1;
      end
      ST_DRY:  if (timerZero) stateNext = ST_EXIT;
      ST_EXIT: if (!carSync)  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  generate
    if (ONE_HOT) begin : g_onehot
      assign codeNext = 4'b0001 << stateNext;
    end else begin : g_binary
      assign codeNext = {2'b00, stateNext};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= ST_IDLE;
      waterOn   <= 1'b0;
      dryerOn   <= 1'b0;
      stateCode <= ONE_HOT ? 4'b0001 : 4'b0000;
    end else begin
      stateQ    <= stateNext;
      waterOn   <= (stateNext == ST_WASH);
      dryerOn   <= (stateNext == ST_DRY);
      stateCode <= codeNext;
    end
  end

  // R1: reset leaves the idle phase with both loads off
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (stateQ == ST_IDLE && !waterOn && !dryerOn));

  // R10: the two loads are mutually exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(waterOn && dryerOn));

  // R2: a synchronized vehicle in idle starts washing
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && carSync) |=> (stateQ == ST_WASH && waterOn));

  // R5: drying ends in the exit wait with the dryer off
  p_dry_done_r5: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DRY && timerZero) |=> (stateQ == ST_EXIT && !dryerOn && !waterOn));

  // R6: the exit wait holds while the vehicle is still present
  p_exit_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_EXIT && carSync) |=> (stateQ == ST_EXIT));

  // R8: sensor changes do not end washing early
  p_wash_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WASH && !timerZero) |=> (stateQ == ST_WASH));

  // R9: one-hot code keeps exactly one bit set
  p_code_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    ONE_HOT |-> ($countones(stateCode) == 1));
endmodule

// File: rtl/wash_sequencer.sv
module wash_sequencer
  import wash_pkg::*;
#(
  parameter int WASH_TICKS  = 300,
  parameter int DRY_TICKS   = 60,
  parameter bit ONE_HOT     = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       carPresent,
  input  logic       tickEn,
  output logic       waterOn,
  output logic       dryerOn,
  output logic [3:0] stateCode
);
  logic      carSync;
  logic      timerZero;
  timerCmd_t cmd;

  wash_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(carPresent), .syncOut(carSync)
  );

  wash_timer #(.WASH_TICKS(WASH_TICKS), .DRY_TICKS(DRY_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cmd(cmd), .timerZero(timerZero)
  );

  wash_ctrl #(.ONE_HOT(ONE_HOT)) u_ctrl (
    .clk(clk), .rst(rst), .carSync(carSync), .timerZero(timerZero),
    .cmd(cmd), .waterOn(waterOn), .dryerOn(dryerOn), .stateCode(stateCode)
  );
endmodule

// File: tb/wash_sequencer_bench.sv
module wash_sequencer_bench;
  localparam int W = 4;
  localparam int D = 2;
  localparam int P_IDLE = 0, P_WASH = 1, P_DRY = 2, P_EXIT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic carPresent = 1'b0;
  logic tickEn = 1'b0;
  logic waterOn, dryerOn, waterOh, dryerOh;
  logic [3:0] stateCode, codeOh;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wash_sequencer #(.WASH_TICKS(W), .DRY_TICKS(D), .ONE_HOT(1'b0)) u_wash_sequencer (
    .clk(clk), .rst(rst), .carPresent(carPresent), .tickEn(tickEn),
    .waterOn(waterOn), .dryerOn(dryerOn), .stateCode(stateCode)
  );

  wash_sequencer #(.WASH_TICKS(W), .DRY_TICKS(D), .ONE_HOT(1'b1)) u_wash_sequencer_oh (
    .clk(clk), .rst(rst), .carPresent(carPresent), .tickEn(tickEn),
    .waterOn(waterOh), .dryerOn(dryerOh), .stateCode(codeOh)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Phase and both loads on both instances (R9 codes, R10 loads).
  task automatic checkPhase(input int ph, input string req);
    check(stateCode == 4'(ph), {req, " binary code"}, stateCode, ph);
    check(codeOh == (4'b0001 << ph), {req, " one-hot code R9"}, codeOh, 1 << ph);
    check(waterOn == (ph == P_WASH) && waterOh == (ph == P_WASH),
          {req, " water R10"}, {waterOn, waterOh}, (ph == P_WASH) ? 3 : 0);
    check(dryerOn == (ph == P_DRY) && dryerOh == (ph == P_DRY),
          {req, " dryer R10"}, {dryerOn, dryerOh}, (ph == P_DRY) ? 3 : 0);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count sampled cycles spent in a phase (sampling at falling edges).
  task automatic measure(input int ph, output int n);
    n = 0;
    while (stateCode == 4'(ph) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; carPresent = 1'b0; tickEn = 1'b0;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    checkPhase(P_IDLE, "R1 after reset");
    cycles(5);
    checkPhase(P_IDLE, "R2 idle with no vehicle");
  endtask

  task automatic t_full_cycle();
    int n;
    tickEn = 1'b1;
    carPresent = 1'b1;
    cycles(2);
    checkPhase(P_IDLE, "R2 still syncing");
    cycles(1);
    checkPhase(P_WASH, "R2 wash start");
    measure(P_WASH, n);
    check(n == W + 1, "R3 wash length", n, W + 1);
    checkPhase(P_DRY, "R4 drying");
    measure(P_DRY, n);
    check(n == D + 1, "R4 dry length", n, D + 1);
    checkPhase(P_EXIT, "R5 exit wait");
    cycles(10);
    checkPhase(P_EXIT, "R6 held while present");
    carPresent = 1'b0;
    cycles(2);
    checkPhase(P_EXIT, "R6 drop still syncing");
    cycles(1);
    checkPhase(P_IDLE, "R6 back to idle");
    tickEn = 1'b0;
  endtask

  task automatic t_freeze();
    int n;
    tickEn = 1'b0;
    carPresent = 1'b1;
    cycles(3);
    checkPhase(P_WASH, "R7 wash entered");
    cycles(40);
    checkPhase(P_WASH, "R7 frozen without tick");
    tickEn = 1'b1;
    measure(P_WASH, n);
    check(n == W + 1, "R7 wash length after stall", n, W + 1);
    tickEn = 1'b0;
    cycles(25);
    checkPhase(P_DRY, "R7 dry frozen without tick");
    tickEn = 1'b1;
    measure(P_DRY, n);
    check(n == D + 1, "R7 dry length after stall", n, D + 1);
    carPresent = 1'b0;
    cycles(3);
    checkPhase(P_IDLE, "R6 idle after leave");
    tickEn = 1'b0;
  endtask

  task automatic t_early_leave();
    int n;
    tickEn = 1'b1;
    carPresent = 1'b1;
    cycles(3);
    checkPhase(P_WASH, "R8 wash entered");
    carPresent = 1'b0;
    measure(P_WASH, n);
    check(n == W + 1, "R8 wash not shortened", n, W + 1);
    measure(P_DRY, n);
    check(n == D + 1, "R8 dry not shortened", n, D + 1);
    checkPhase(P_EXIT, "R5 exit after dry");
    cycles(1);
    checkPhase(P_IDLE, "R6 immediate idle");
    tickEn = 1'b0;
  endtask

  task automatic t_reset_mid();
    tickEn = 1'b1;
    carPresent = 1'b1;
    cycles(3 + W + 2);
    checkPhase(P_DRY, "R1 in dry before reset");
    rst = 1'b1;
    cycles(1);
    checkPhase(P_IDLE, "R1 reset from dry");
    rst = 1'b0;
    carPresent = 1'b0;
    tickEn = 1'b0;
    cycles(4);
    checkPhase(P_IDLE, "R1 stays idle");
  endtask

  initial begin
    t_reset();
    t_full_cycle();
    t_freeze();
    t_early_leave();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule